// File: doc/BRIEF.md
# Rotating-Parity Block Array with Read-Modify-Write Update

This block models a small disk array: a set of disks, each an internal block memory with a fixed access latency. Data is spread over the array in stripes, and one block of each stripe holds parity. A client addresses the array by logical block number. The block works out the stripe, the data disk and the parity disk from that number. A logical read fetches one physical block. A logical write changes one data block and keeps the stripe parity correct. It does this without touching the other data blocks of the stripe: the old data and old parity are fetched first, the new parity is formed from them, and then both blocks are stored.

The parity disk moves by one position per stripe, so writes to different stripes fall on different parity disks. A raw physical read lets the client fetch any disk and row directly, which makes the parity blocks visible at the ports. Only one request is in flight at a time. A busy flag covers the whole physical sequence, and a one-cycle done strobe marks its end.

Top module: `raid_rmw_engine`

## Requirements
- R1: After reset, busy and done are low, rd_data is zero, and every block of every disk reads as zero.
- R2: For logical block L with K = NDISK-1 data blocks per stripe, the stripe (and disk row) is L / K. The parity disk is NDISK-1 minus (stripe mod NDISK). Position L mod K goes to the non-parity disks in increasing disk order.
- R3: A logical read returns the value most recently written to that logical block.
- R4: After a write, the new parity equals old parity XOR old data XOR new data, so the XOR of all blocks in the stripe is zero.
- R5: A logical write issues exactly four physical operations, one at a time, in this order: read data disk, read parity disk, write data disk, write parity disk. A read issues exactly one.
- R6: A request is accepted only while busy is low. Busy rises in the cycle after acceptance. Requests presented while busy have no effect on any disk.
- R7: done is high for exactly one cycle at the end of each request, and rd_data then holds the block that was read.
- R8: A write changes only the data block and the parity block of its own stripe; blocks in other stripes keep their values.
- R9: Opcode 2 (raw read) returns the physical block at row req_row of disk req_disk. Opcode 0 is a logical read and opcode 1 is a logical write.
- R10: Each physical access takes LAT+2 cycles from issue to the next step. With an accept edge counted as 1, done is seen after edge LAT+3 for reads and after edge 4*(LAT+2)+1 for writes.
- R11: Opcode 3, and logical requests with L at or above ROWS*(NDISK-1), are not accepted: busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 logical read, 1 logical write, 2 raw read, 3 reserved |
| req_lba | input | LBA_W | Logical block number |
| req_disk | input | DISK_W | Disk index for raw read |
| req_row | input | ROW_W | Row index for raw read |
| req_wdata | input | DATA_W | New block data for writes |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion strobe |
| rd_data | output | DATA_W | Block returned by the last read |

## Verification
Most internal faults stay hidden until the client reads back through the array. A wrong parity disk or a wrong data disk choice appears as soon as the affected stripe is fetched with raw reads: the stripe XOR is no longer zero, or a data block sits on the wrong disk. A stale old-data or old-parity register corrupts parity without changing any logical read, so every write is followed at once by a raw sweep of its stripe. Sequencing faults change the cycle count to done and are caught on the same request.

// File: rtl/raid_rmw_pkg.sv
package raid_rmw_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_RAW   = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RD_DAT,
    S_RD_DAT_W,
    S_RD_PAR,
    S_RD_PAR_W,
    S_WR_DAT,
    S_WR_DAT_W,
    S_WR_PAR,
    S_WR_PAR_W,
    S_DONE
  } seq_e;

endpackage

// File: rtl/raid_stripe_map.sv
module raid_stripe_map #(
  parameter int NDISK = 4,
  parameter int ROWS  = 8,
  localparam int NBLK   = ROWS * (NDISK - 1),
  localparam int LBA_W  = $clog2(NBLK),
  localparam int DISK_W = $clog2(NDISK),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic [LBA_W-1:0]  lba,
  output logic [ROW_W-1:0]  row,
  output logic [DISK_W-1:0] data_disk,
  output logic [DISK_W-1:0] par_disk,
  output logic              in_range
);

  int stripe_v;
  int slot_v;
  int par_v;

  always_comb begin
    stripe_v  = int'(lba) / (NDISK - 1);
    slot_v    = int'(lba) % (NDISK - 1);
    // parity starts on the last disk and steps down one disk per stripe
    par_v     = (NDISK - 1) - (stripe_v % NDISK);
    in_range  = int'(lba) < NBLK;
    row       = ROW_W'(stripe_v);
    par_disk  = DISK_W'(par_v);
    data_disk = (slot_v < par_v) ? DISK_W'(slot_v) : DISK_W'(slot_v + 1);
  end

endmodule

// File: rtl/raid_disk_model.sv
module raid_disk_model #(
  parameter int ROWS   = 8,
  parameter int DATA_W = 32,
  parameter int LAT    = 3,
  localparam int ROW_W = $clog2(ROWS),
  localparam int CNT_W = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_we,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [ROWS];
  logic              pend_q, pend_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              fire;
  logic              we_q;
  logic [ROW_W-1:0]  row_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    pend_n = pend_q;
    cnt_n  = cnt_q;
    fire   = 1'b0;
    if (cmd_valid) begin
      pend_n = 1'b1;
      cnt_n  = CNT_W'(LAT - 1);
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        fire   = 1'b1;
        pend_n = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      cnt_q   <= '0;
      ack     <= 1'b0;
      we_q    <= 1'b0;
      row_q   <= '0;
      wdata_q <= '0;
      rdata   <= '0;
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
    end else begin
      pend_q <= pend_n;
      cnt_q  <= cnt_n;
      ack    <= fire;
      if (cmd_valid) begin
        we_q    <= cmd_we;
        row_q   <= cmd_row;
        wdata_q <= cmd_wdata;
      end
      if (fire && we_q)  mem[row_q] <= wdata_q;
      if (fire && !we_q) rdata      <= mem[row_q];
    end
  end

  // R10
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  // R5
  one_cmd_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !pend_q);

endmodule

// File: rtl/raid_rmw_seq.sv
module raid_rmw_seq
  import raid_rmw_pkg::*;
#(
  parameter int NDISK  = 4,
  parameter int ROWS   = 8,
  parameter int DATA_W = 32,
  localparam int DISK_W = $clog2(NDISK),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  input  logic [1:0]                    req_op,
  input  logic                          lba_ok,
  input  logic [ROW_W-1:0]              map_row,
  input  logic [DISK_W-1:0]             map_data,
  input  logic [DISK_W-1:0]             map_par,
  input  logic [DISK_W-1:0]             raw_disk,
  input  logic [ROW_W-1:0]              raw_row,
  input  logic [DATA_W-1:0]             req_wdata,
  input  logic [NDISK-1:0]              dsk_ack,
  input  logic [NDISK-1:0][DATA_W-1:0]  dsk_rdata,
  output logic [NDISK-1:0]              cmd_valid,
  output logic                          cmd_we,
  output logic [ROW_W-1:0]              cmd_row,
  output logic [DATA_W-1:0]             cmd_wdata,
  output logic                          busy,
  output logic                          done,
  output logic [DATA_W-1:0]             rd_data
);

  seq_e              st_q, st_n;
  op_e               op_q;
  op_e               op_in;
  logic              legal;
  logic              accept;
  logic              cap_dat, cap_par;
  logic [ROW_W-1:0]  row_q;
  logic [DISK_W-1:0] dsk_q, par_q;
  logic [DATA_W-1:0] wdata_q, old_dat_q, old_par_q;

  assign op_in = op_e'(req_op);

  always_comb begin
    unique case (op_in)
      OP_READ, OP_WRITE: legal = lba_ok;
      OP_RAW:            legal = int'(raw_disk) < NDISK;
      default:           legal = 1'b0;
    endcase
  end

  always_comb begin
    st_n      = st_q;
    accept    = 1'b0;
    cap_dat   = 1'b0;
    cap_par   = 1'b0;
    cmd_valid = '0;
    cmd_we    = 1'b0;
    cmd_wdata = wdata_q;
    unique case (st_q)
      S_IDLE: if (req_valid && legal) begin
        accept = 1'b1;
        st_n   = S_RD_DAT;
      end
      S_RD_DAT: begin
        cmd_valid[dsk_q] = 1'b1;
        st_n = S_RD_DAT_W;
      end
      S_RD_DAT_W: if (dsk_ack[dsk_q]) begin
        cap_dat = 1'b1;
        st_n    = (op_q == OP_WRITE) ? S_RD_PAR : S_DONE;
      end
      S_RD_PAR: begin
        cmd_valid[par_q] = 1'b1;
        st_n = S_RD_PAR_W;
      end
      S_RD_PAR_W: if (dsk_ack[par_q]) begin
        cap_par = 1'b1;
        st_n    = S_WR_DAT;
      end
      S_WR_DAT: begin
        cmd_valid[dsk_q] = 1'b1;
        cmd_we = 1'b1;
        st_n   = S_WR_DAT_W;
      end
      S_WR_DAT_W: if (dsk_ack[dsk_q]) st_n = S_WR_PAR;
      S_WR_PAR: begin
        cmd_valid[par_q] = 1'b1;
        cmd_we    = 1'b1;
        cmd_wdata = old_par_q ^ old_dat_q ^ wdata_q;
        st_n      = S_WR_PAR_W;
      end
      S_WR_PAR_W: if (dsk_ack[par_q]) st_n = S_DONE;
      S_DONE:  st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q      <= OP_READ;
      row_q     <= '0;
      dsk_q     <= '0;
      par_q     <= '0;
      wdata_q   <= '0;
      old_dat_q <= '0;
      old_par_q <= '0;
    end else begin
      if (accept) begin
        op_q    <= op_in;
        row_q   <= (op_in == OP_RAW) ? raw_row  : map_row;
        dsk_q   <= (op_in == OP_RAW) ? raw_disk : map_data;
        par_q   <= map_par;
        wdata_q <= req_wdata;
      end
      if (cap_dat) old_dat_q <= dsk_rdata[dsk_q];
      if (cap_par) old_par_q <= dsk_rdata[par_q];
    end
  end

  assign cmd_row = row_q;
  assign busy    = (st_q != S_IDLE);
  assign done    = (st_q == S_DONE);
  assign rd_data = old_dat_q;

  // operation tally for the sequence checks below
  logic [2:0] ops_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ops_q <= '0;
    else if (accept)     ops_q <= '0;
    else if (|cmd_valid) ops_q <= ops_q + 1'b1;
  end

  // R5
  write_four_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q == OP_WRITE) |-> ops_q == 3'd4);

  // R5
  read_one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_q != OP_WRITE) |-> ops_q == 3'd1);

  // R6
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(row_q) && $stable(wdata_q) && $stable(dsk_q)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/raid_rmw_engine.sv
module raid_rmw_engine #(
  parameter int NDISK  = 4,
  parameter int ROWS   = 8,
  parameter int DATA_W = 32,
  parameter int LAT    = 3,
  localparam int NBLK   = ROWS * (NDISK - 1),
  localparam int LBA_W  = $clog2(NBLK),
  localparam int DISK_W = $clog2(NDISK),
  localparam int ROW_W  = $clog2(ROWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [LBA_W-1:0]  req_lba,
  input  logic [DISK_W-1:0] req_disk,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);

  logic [ROW_W-1:0]             map_row;
  logic [DISK_W-1:0]            map_data, map_par;
  logic                         map_ok;
  logic [NDISK-1:0]             cmd_valid;
  logic                         cmd_we;
  logic [ROW_W-1:0]             cmd_row;
  logic [DATA_W-1:0]            cmd_wdata;
  logic [NDISK-1:0]             dsk_ack;
  logic [NDISK-1:0][DATA_W-1:0] dsk_rdata;

  raid_stripe_map #(.NDISK(NDISK), .ROWS(ROWS)) i_map (
    .lba       (req_lba),
    .row       (map_row),
    .data_disk (map_data),
    .par_disk  (map_par),
    .in_range  (map_ok)
  );

  raid_rmw_seq #(.NDISK(NDISK), .ROWS(ROWS), .DATA_W(DATA_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .lba_ok    (map_ok),
    .map_row   (map_row),
    .map_data  (map_data),
    .map_par   (map_par),
    .raw_disk  (req_disk),
    .raw_row   (req_row),
    .req_wdata (req_wdata),
    .dsk_ack   (dsk_ack),
    .dsk_rdata (dsk_rdata),
    .cmd_valid (cmd_valid),
    .cmd_we    (cmd_we),
    .cmd_row   (cmd_row),
    .cmd_wdata (cmd_wdata),
    .busy      (busy),
    .done      (done),
    .rd_data   (rd_data)
  );

  for (genvar d = 0; d < NDISK; d++) begin : g_disk
    raid_disk_model #(.ROWS(ROWS), .DATA_W(DATA_W), .LAT(LAT)) i_disk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid[d]),
      .cmd_we    (cmd_we),
      .cmd_row   (cmd_row),
      .cmd_wdata (cmd_wdata),
      .ack       (dsk_ack[d]),
      .rdata     (dsk_rdata[d])
    );
  end

  // R5
  single_disk_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_valid));

  // R2
  data_not_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    map_ok |-> (map_data != map_par));

endmodule

// File: tb/test_raid_rmw_engine.sv
`timescale 1ns/1ps
module test_raid_rmw_engine;

  localparam int ND   = 4;
  localparam int RW   = 8;
  localparam int DW   = 32;
  localparam int LAT  = 3;
  localparam int K    = ND - 1;
  localparam int NB   = RW * K;
  localparam int LBAW = $clog2(NB);
  localparam int DKW  = $clog2(ND);
  localparam int RWW  = $clog2(RW);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic [1:0]      req_op;
  logic [LBAW-1:0] req_lba;
  logic [DKW-1:0]  req_disk;
  logic [RWW-1:0]  req_row;
  logic [DW-1:0]   req_wdata;
  logic            busy, done;
  logic [DW-1:0]   rd_data;

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] model [ND][RW];

  always #2.5 clk = ~clk;

  raid_rmw_engine #(.NDISK(ND), .ROWS(RW), .DATA_W(DW), .LAT(LAT)) i_raid_rmw_engine (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_lba(req_lba), .req_disk(req_disk), .req_row(req_row),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void place(input int l, output int row, output int dd, output int pd);
    int slot;
    row  = l / K;
    slot = l % K;
    pd   = (ND - 1) - (row % ND);
    dd   = (slot < pd) ? slot : slot + 1;
  endfunction

  task automatic run_req(input logic [1:0] op, input int l, input int dk, input int rw,
                         input logic [DW-1:0] wd, output int cyc, output logic [DW-1:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_lba = LBAW'(l);
    req_disk = DKW'(dk); req_row = RWW'(rw); req_wdata = wd;
    @(posedge clk); cyc = 1;
    @(negedge clk); req_valid = 1'b0;
    while (!done) begin
      @(posedge clk); cyc++;
      @(negedge clk);
    end
    rd = rd_data;
  endtask

  task automatic do_write(input int l, input logic [DW-1:0] v);
    int row, dd, pd, cyc;
    logic [DW-1:0] rd;
    place(l, row, dd, pd);
    run_req(2'd1, l, 0, 0, v, cyc, rd);
    model[pd][row] = model[pd][row] ^ model[dd][row] ^ v;
    model[dd][row] = v;
  endtask

  task automatic raw_rd(input int dk, input int rw, output logic [DW-1:0] v);
    int cyc;
    run_req(2'd2, 0, dk, rw, '0, cyc, v);
  endtask

  // R2 R4 R9: every physical block of a stripe matches the model and XORs to zero
  task automatic sweep_stripe(input int rw);
    logic [DW-1:0] v, acc;
    acc = '0;
    for (int d = 0; d < ND; d++) begin
      raw_rd(d, rw, v);
      check($sformatf("R2/R9 raw disk %0d row %0d", d, rw), v, model[d][rw]);
      acc ^= v;
    end
    check($sformatf("R4 stripe %0d xor", rw), acc, '0);
  endtask

  task automatic t_reset;
    logic [DW-1:0] v;
    int cyc;
    check("R1 busy after reset", {31'd0, busy}, '0);
    check("R1 done after reset", {31'd0, done}, '0);
    check("R1 rd_data after reset", rd_data, '0);
    run_req(2'd0, NB - 1, 0, 0, '0, cyc, v);
    check("R1 last block zero", v, '0);
    sweep_stripe(0);
  endtask

  task automatic t_fill;
    int row, dd, pd;
    for (int l = 0; l < NB; l++) begin
      do_write(l, 32'hA500_0000 + l * 32'h0103_0507);
      place(l, row, dd, pd);
      sweep_stripe(row);
    end
  endtask

  task automatic t_readback;
    logic [DW-1:0] v;
    int cyc;
    for (int l = 0; l < NB; l++) begin
      run_req(2'd0, l, 0, 0, '0, cyc, v);
      check($sformatf("R3 read lba %0d", l), v, 32'hA500_0000 + l * 32'h0103_0507);
    end
  endtask

  task automatic t_isolation;
    logic [DW-1:0] v;
    do_write(7, 32'hDEAD_BEEF);
    do_write(7, 32'h1234_5678);
    sweep_stripe(2);
    // R8: neighbouring stripes keep their blocks
    for (int d = 0; d < ND; d++) begin
      raw_rd(d, 1, v); check("R8 stripe 1 untouched", v, model[d][1]);
      raw_rd(d, 3, v); check("R8 stripe 3 untouched", v, model[d][3]);
    end
  endtask

  task automatic t_busy_ignore;
    logic [DW-1:0] v;
    int cyc;
    int row, dd, pd;
    place(4, row, dd, pd);
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd1; req_lba = LBAW'(4); req_wdata = 32'h0F0F_0F0F;
    @(posedge clk);
    @(negedge clk);
    check("R6 busy after accept", {31'd0, busy}, 32'd1);
    req_lba = LBAW'(10); req_wdata = 32'hFFFF_0000;
    repeat (6) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    model[pd][row] = model[pd][row] ^ model[dd][row] ^ 32'h0F0F_0F0F;
    model[dd][row] = 32'h0F0F_0F0F;
    @(negedge clk);
    check("R7 done single cycle", {31'd0, done}, '0);
    run_req(2'd0, 10, 0, 0, '0, cyc, v);
    check("R6 ignored write lba 10", v, 32'hA500_0000 + 10 * 32'h0103_0507);
    run_req(2'd0, 4, 0, 0, '0, cyc, v);
    check("R3 lba 4 new value", v, 32'h0F0F_0F0F);
    sweep_stripe(row);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'd3; req_lba = '0; req_wdata = 32'h5555_5555;
    @(posedge clk); @(negedge clk);
    check("R11 op3 not accepted", {31'd0, busy}, '0);
    req_op = 2'd1; req_lba = LBAW'(NB);
    @(posedge clk); @(negedge clk);
    check("R11 lba out of range", {31'd0, busy}, '0);
    req_valid = 1'b0;
    sweep_stripe(0);
  endtask

  task automatic t_latency;
    logic [DW-1:0] v;
    int cyc;
    run_req(2'd0, 2, 0, 0, '0, cyc, v);
    check("R10 read latency", cyc, LAT + 3);
    run_req(2'd1, 2, 0, 0, 32'h7777_0001, cyc, v);
    check("R10 write latency", cyc, 4 * (LAT + 2) + 1);
    check("R7 write rd_data holds old data", v, 32'hA500_0000 + 2 * 32'h0103_0507);
    begin
      int row, dd, pd;
      place(2, row, dd, pd);
      model[pd][row] = model[pd][row] ^ model[dd][row] ^ 32'h7777_0001;
      model[dd][row] = 32'h7777_0001;
    end
    sweep_stripe(0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int d = 0; d < ND; d++)
      for (int r = 0; r < RW; r++) model[d][r] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_lba = '0;
    req_disk = '0; req_row = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_readback();
    t_isolation();
    t_busy_ignore();
    t_illegal();
    t_latency();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule